// File: doc/BRIEF.md
# Prioritized Interrupt Pending and Vector Register

This block holds a set of 32 interrupt pending flags for one end of a serial link bridge. A pending flag can be raised in three ways: by a local interrupt source, by a software write to the pending/set register, or by an interrupt packet received from the far end of the link. Software reads a vector register to learn the index of the most urgent pending interrupt. Bit 0 is the most urgent and bit 31 the least. Writing an index to the same vector register clears that one interrupt.

A mode bit decides where pending status goes. In local mode, the block drives its own interrupt output, gated by a global enable. In forwarding mode, the pending word is offered to the link transmitter. Every bit the transmitter accepts is cleared here. Received interrupt packets are steered by a pointer register. Their status reaches the pending flags only when the pointer holds the pending/set register offset, 14h, which is also the pointer's reset value.

Top module: `irq_vector_regs`

## Requirements
- R1: After a synchronous reset, all pending bits, the control register and irq_out are 0, the pointer register reads 14h, and bus_rdata and bus_rvalid are 0.
- R2: A bus write to the pending/set register (offset 14h) sets every pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged. A read of offset 14h returns the pending word.
- R3: In any cycle where bit i of local_irq is 1, pending bit i is set at the next clock edge.
- R4: A read of the vector register (offset 10h) returns the index of the lowest-numbered pending bit in bits [4:0], with bit 31 equal to 0. When no bit is pending, it returns bit 31 = 1 and bits [4:0] = 0. All other bits read 0.
- R5: A bus write to the vector register clears the single pending bit whose index is given by bus_wdata[4:0]. Bits [31:5] of the write data are ignored, and all other pending bits are kept.
- R6: When pkt_valid is 1 and the pointer register (offset 18h, 8 bits, read/write) holds 14h, the bits of pkt_status are set into the pending word. When the pointer holds any other value, the packet leaves the pending word unchanged.
- R7: When the control register's bit 0 (local mode) is 0 and at least one bit is pending, fwd_valid is 1 and fwd_status equals the pending word. In a cycle where fwd_valid and fwd_accept are both 1, every bit shown on fwd_status is cleared. When local mode is 1, fwd_valid is 0 and fwd_accept has no effect.
- R8: irq_out is registered. After each clock edge it equals (local mode AND enable AND any bit pending), evaluated on the state before that edge. Enable is bit 1 of the control register at offset 00h.
- R9: If a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: A read returns its data on bus_rdata one cycle later, with bus_rvalid = 1 in that cycle. Offset 00h reads back the control bits, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| local_irq | input | 32 | Local interrupt sources, one per pending bit |
| pkt_valid | input | 1 | A received interrupt packet is present |
| pkt_status | input | 32 | Status word carried by the received packet |
| fwd_valid | output | 1 | Pending status offered for forwarding |
| fwd_status | output | 32 | Pending word offered for forwarding |
| fwd_accept | input | 1 | The link has taken the forwarded status |
| irq_out | output | 1 | Interrupt output in local mode |

## Verification
The bench builds the block with its default parameters: 32 pending bits and 8-bit offsets, with the pending/set register at 14h. Because the full 32-bit width is used, the vector readback can be swept over every index in two ways. The first sweep drains an all-ones word one bit at a time. The second uses sparse words whose only other pending bit is the least urgent one. The same configuration reaches the remaining corner cases: the empty-vector flag, a set and a clear hitting the same bit, packets steered away by the pointer, and the clear on forwarding.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef struct packed {
    logic enable;
    logic local_mode;
  } irqv_ctrl_t;

  localparam int unsigned IRQV_VEC_NONE_BIT = 31;
endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));

  // R5
  drop_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0));

  // R2
  rise_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~$past(pend_q) & pend_q & ~$past(set_mask)) == '0));
endmodule

// File: rtl/irqv_regfile.sv
module irqv_regfile
  import irqv_pkg::*;
#(
  parameter int unsigned N        = 32,
  parameter int unsigned IW       = $clog2(N),
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 32,
  parameter logic [AW-1:0] OFF_CTRL = 8'h00,
  parameter logic [AW-1:0] OFF_VEC  = 8'h10,
  parameter logic [AW-1:0] OFF_PEND = 8'h14,
  parameter logic [AW-1:0] OFF_PTR  = 8'h18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic [N-1:0]  pend_q,
  input  logic [IW-1:0] vec_idx,
  input  logic          vec_any,
  output irqv_ctrl_t    ctrl_q,
  output logic [AW-1:0] ptr_q,
  output logic [N-1:0]  sw_set,
  output logic [N-1:0]  sw_clr
);
  localparam int unsigned SEL_W = (IW < 5) ? 5 : IW;

  logic wr_ctrl, wr_vec, wr_pend, wr_ptr, rd_en;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] vec_word;
  logic [SEL_W-1:0] clr_sel;

  assign wr_ctrl = bus_valid & bus_write & (bus_addr == OFF_CTRL);
  assign wr_vec  = bus_valid & bus_write & (bus_addr == OFF_VEC);
  assign wr_pend = bus_valid & bus_write & (bus_addr == OFF_PEND);
  assign wr_ptr  = bus_valid & bus_write & (bus_addr == OFF_PTR);
  assign rd_en   = bus_valid & ~bus_write;

  assign sw_set  = wr_pend ? bus_wdata[N-1:0] : '0;
  assign clr_sel = SEL_W'(bus_wdata[4:0]);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_clr
      assign sw_clr[g] = wr_vec & (clr_sel == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    vec_word = '0;
    if (vec_any) vec_word[IW-1:0] = vec_idx;
    else         vec_word[IRQV_VEC_NONE_BIT] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_CTRL)      rd_mux[1:0] = {ctrl_q.enable, ctrl_q.local_mode};
    else if (bus_addr == OFF_VEC)  rd_mux = vec_word;
    else if (bus_addr == OFF_PEND) rd_mux[N-1:0] = pend_q;
    else if (bus_addr == OFF_PTR)  rd_mux[AW-1:0] = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      ptr_q      <= OFF_PEND;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.local_mode <= bus_wdata[0];
        ctrl_q.enable     <= bus_wdata[1];
      end
      if (wr_ptr) ptr_q <= bus_wdata[AW-1:0];
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? rd_mux : '0;
    end
  end

  // R5
  one_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw_clr));

  // R10
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid & ~bus_write) |=> bus_rvalid);
endmodule

// File: rtl/irq_vector_regs.sv
module irq_vector_regs
  import irqv_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32,
  parameter logic [AW-1:0] OFF_CTRL = 8'h00,
  parameter logic [AW-1:0] OFF_VEC  = 8'h10,
  parameter logic [AW-1:0] OFF_PEND = 8'h14,
  parameter logic [AW-1:0] OFF_PTR  = 8'h18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic [N-1:0]  local_irq,
  input  logic          pkt_valid,
  input  logic [N-1:0]  pkt_status,
  output logic          fwd_valid,
  output logic [N-1:0]  fwd_status,
  input  logic          fwd_accept,
  output logic          irq_out
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]  pend_q, sw_set, sw_clr, pkt_set, fwd_clr, set_mask, clr_mask;
  logic [IW-1:0] vec_idx;
  logic          vec_any;
  irqv_ctrl_t    ctrl_q;
  logic [AW-1:0] ptr_q;

  irqv_prio_enc #(.N(N), .IW(IW)) u_enc (
    .req(pend_q), .idx(vec_idx), .any(vec_any)
  );

  irqv_regfile #(
    .N(N), .IW(IW), .AW(AW), .DW(DW),
    .OFF_CTRL(OFF_CTRL), .OFF_VEC(OFF_VEC), .OFF_PEND(OFF_PEND), .OFF_PTR(OFF_PTR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pend_q(pend_q), .vec_idx(vec_idx), .vec_any(vec_any),
    .ctrl_q(ctrl_q), .ptr_q(ptr_q), .sw_set(sw_set), .sw_clr(sw_clr)
  );

  assign pkt_set    = (pkt_valid && ptr_q == OFF_PEND) ? pkt_status : '0;
  assign fwd_valid  = ~ctrl_q.local_mode & vec_any;
  assign fwd_status = fwd_valid ? pend_q : '0;
  assign fwd_clr    = (fwd_valid & fwd_accept) ? pend_q : '0;
  assign set_mask   = sw_set | local_irq | pkt_set;
  assign clr_mask   = sw_clr | fwd_clr;

  irqv_pending #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= ctrl_q.local_mode & ctrl_q.enable & vec_any;
  end

  // R8
  irq_needs_local_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(ctrl_q.local_mode) && $past(pend_q) != '0));

  // R4
  vec_points_low_chk: assert property (@(posedge clk) disable iff (rst)
    vec_any |-> (pend_q[vec_idx] && ((pend_q & ((N'(1) << vec_idx) - N'(1))) == '0)));

  // R7
  fwd_drains_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_accept && set_mask == '0) |=> (pend_q == '0));
endmodule

// File: tb/irq_vector_regs_tb.sv
module irq_vector_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid;
  logic [31:0] local_irq, pkt_status, fwd_status;
  logic        pkt_valid, fwd_valid, fwd_accept, irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_regs u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .local_irq(local_irq), .pkt_valid(pkt_valid),
    .pkt_status(pkt_status), .fwd_valid(fwd_valid), .fwd_status(fwd_status),
    .fwd_accept(fwd_accept), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    check("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] vec_of(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return 32'h8000_0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, p;
    rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    local_irq = 0; pkt_valid = 0; pkt_status = 0; fwd_accept = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(8'h14, d); check("R1 pending", d, 32'd0);
    rd(8'h00, d); check("R1 ctrl", d, 32'd0);
    rd(8'h18, d); check("R1 pointer", d, 32'h14);
    rd(8'h10, d); check("R4 empty vector", d, 32'h8000_0000);

    wr(8'h00, 32'h3);
    rd(8'h00, d); check("R10 ctrl readback", d, 32'h3);
    rd(8'h40, d); check("R10 unmapped", d, 32'd0);

    // R4 R5 sweep: drain all-ones one bit at a time
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R2 set all", d, 32'hFFFF_FFFF);
    p = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) begin
      rd(8'h10, d); check("R4 drain vector", d, vec_of(p));
      wr(8'h10, 32'hFFFF_FFE0 | i);
      p[i] = 1'b0;
      rd(8'h14, d); check("R5 single clear", d, p);
    end
    rd(8'h10, d); check("R4 drained", d, 32'h8000_0000);

    // sparse sweep: bit i and bit 31
    for (int i = 0; i < 31; i++) begin
      wr(8'h14, 32'h8000_0000 | (32'd1 << i));
      rd(8'h10, d); check("R4 sparse vector", d, i);
      wr(8'h10, i);
      rd(8'h10, d); check("R4 sparse next", d, 32'd31);
      wr(8'h10, 31);
    end

    // R2 zeros have no effect
    wr(8'h14, 32'h0000_00A0);
    wr(8'h14, 32'h0000_0000);
    rd(8'h14, d); check("R2 zero write", d, 32'h0000_00A0);
    // R8 irq asserted in local mode with enable
    @(negedge clk); #1;
    check("R8 irq on", {31'd0, irq_out}, 32'd1);
    wr(8'h00, 32'h1);
    @(negedge clk);
    check("R8 irq disabled", {31'd0, irq_out}, 32'd0);
    wr(8'h00, 32'h3);
    wr(8'h10, 5); wr(8'h10, 7);
    @(negedge clk);
    check("R8 irq empty", {31'd0, irq_out}, 32'd0);

    // R3 local source
    @(negedge clk); local_irq = 32'h0001_0000;
    @(negedge clk); local_irq = 0;
    rd(8'h14, d); check("R3 local set", d, 32'h0001_0000);

    // R9 set and clear same bit
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h10; bus_wdata = 32'd3; local_irq = 32'h8;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; local_irq = 0;
    rd(8'h14, d); check("R9 set wins", d, 32'h0001_0008);
    wr(8'h10, 3); wr(8'h10, 16);

    // R6 packets
    @(negedge clk); pkt_valid = 1; pkt_status = 32'h0000_0C00;
    @(negedge clk); pkt_valid = 0;
    rd(8'h14, d); check("R6 packet set", d, 32'h0000_0C00);
    wr(8'h18, 32'h20);
    rd(8'h18, d); check("R6 pointer rw", d, 32'h20);
    @(negedge clk); pkt_valid = 1; pkt_status = 32'h0000_0003;
    @(negedge clk); pkt_valid = 0;
    rd(8'h14, d); check("R6 packet steered away", d, 32'h0000_0C00);
    wr(8'h18, 32'h14);

    // R7 forwarding
    @(negedge clk); fwd_accept = 1;
    @(negedge clk); fwd_accept = 0;
    rd(8'h14, d); check("R7 accept ignored in local", d, 32'h0000_0C00);
    check("R7 no fwd in local", {31'd0, fwd_valid}, 32'd0);
    wr(8'h00, 32'h2);
    #1;
    check("R7 fwd valid", {31'd0, fwd_valid}, 32'd1);
    check("R7 fwd status", fwd_status, 32'h0000_0C00);
    @(negedge clk);
    check("R8 no irq when forwarding", {31'd0, irq_out}, 32'd0);
    fwd_accept = 1;
    @(negedge clk); fwd_accept = 0;
    rd(8'h14, d); check("R7 forwarded cleared", d, 32'd0);
    check("R7 fwd idle", {31'd0, fwd_valid}, 32'd0);
    @(negedge clk); fwd_accept = 1; local_irq = 32'h4; wr(8'h14, 32'h1);
    @(negedge clk); fwd_accept = 0; local_irq = 0;
    rd(8'h14, d); check("R9 set beats forward clear", d, 32'h4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule